// File: doc/BRIEF.md
# Shared-Bus Grant Arbiter with Rotating Processor Slot

This block decides, cycle by cycle, which requester owns a shared memory bus. Four DMA channels compete with one processor slot, which in turn holds two requesters: a DSP and a CPU. A separate legacy DMA request sits above all of them and, when raised, takes the bus in any mode. Grants are combinational from the current requests and the arbiter state, so a requester sees its grant in the same cycle it asks. The rotation state moves on at the clock edge that ends that cycle.

Two arbitration policies are selected by a mode bit taken from bit 31 of the global control word. Fixed priority ranks the channels by index and gives the bus to the processor slot only when every channel is quiet. Rotating mode walks the candidates in a ring. Each channel gets one beat per turn. The processor slot keeps the bus for a configurable cycle budget, encoded in bits 19:16 of the same control word. Idle candidates are passed over in the same cycle, so no beat is lost to a requester with nothing to do.

Top module: `bus_grant_arbiter`

## Requirements
- R1: `rot_mode` (bit 31 of the control word) selects the policy: 0 gives fixed priority and 1 gives rotation.
- R2: In fixed mode the grant goes to the lowest-indexed requesting channel. The DSP is granted only when no channel requests, and the CPU only when neither a channel nor the DSP requests.
- R3: When `legacy_req` is high, only `legacy_gnt` is asserted, in both modes. The rotation pointer and the slot counter hold, so the rotation resumes where it stopped.
- R4: In rotating mode the ring order is channel 0, 1, 2, 3, then the processor slot, then back to channel 0. The ring starts at channel 0 after reset. A channel holds the grant for a single cycle, and the next search starts at the following ring position.
- R5: A ring position with no pending request is skipped within the same cycle. The first requesting position at or after the pointer wins.
- R6: `yield_code` (bits 19:16 of the control word) sets the slot budget. Code 0 means 0 cycles, and the slot is then never granted in rotating mode. Code k from 1 to 15 grants the slot for 2^(k-1) consecutive cycles (1 to 16384) while it keeps requesting, and the ring then continues at channel 0.
- R7: Whenever the processor slot owns the bus and both the DSP and the CPU request, the DSP is granted and the CPU is not.
- R8: If the DSP and the CPU both drop their requests while the slot holds unused budget, the slot releases at once. In that same cycle the search restarts at channel 0, and the leftover budget is discarded.
- R9: With no requests at all, no grant is asserted. Outside an active slot the rotation pointer holds, so the next grant goes to the position that was due.
- R10: At most one grant is high in any cycle, and a grant is only ever given to a requester whose request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_mode | input | 1 | Policy select from control bit 31 (0 fixed, 1 rotating) |
| yield_code | input | 4 | Slot budget code from control bits 19:16 |
| legacy_req | input | 1 | Legacy DMA request, highest priority |
| chan_req | input | 4 | DMA channel requests, bit i for channel i |
| dsp_req | input | 1 | DSP request inside the processor slot |
| cpu_req | input | 1 | CPU request inside the processor slot |
| legacy_gnt | output | 1 | Grant to the legacy DMA requester |
| chan_gnt | output | 4 | Grants to the DMA channels |
| dsp_gnt | output | 1 | Grant to the DSP |
| cpu_gnt | output | 1 | Grant to the CPU |

## Verification
Every grant is due in the same cycle as the requests that cause it. The pointer and slot counter affect only the grants of the next cycle, one clock edge later. The bench drives each cycle's requests just after a falling edge and compares all seven grant bits one time unit later, before the rising edge that advances the state. Each compare therefore checks the result of the state left by the previous edge together with the current inputs. Slot budgets are checked by counting consecutive DSP grants across successive cycles, and by confirming that channel 0 is granted in the cycle right after the budget runs out.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_CH     = 4;
  localparam int CODE_W     = 4;
  localparam int CNT_W      = (1 << CODE_W) - 1;
  localparam int NUM_CAND   = NUM_CH + 1;
  localparam int IDX_W      = $clog2(NUM_CAND);

  typedef enum logic {
    POL_FIXED  = 1'b0,
    POL_ROTATE = 1'b1
  } arb_policy_e;
endpackage

// File: rtl/arb_budget_decode.sv
module arb_budget_decode #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  cycles
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // code 0 -> no slot; code k -> 2^(k-1) cycles
  always_comb begin
    if (code == '0) cycles = '0;
    else            cycles = ONE << (code - CODE_W'(1));
  end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] chan_req,
  input  logic              dsp_req,
  input  logic              cpu_req,
  output logic [NUM_CH-1:0] chan_sel,
  output logic              dsp_sel,
  output logic              cpu_sel
);
  logic any_ch;

  // lowest index wins
  always_comb begin
    chan_sel = '0;
    any_ch   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_req[i] && !any_ch) begin
        chan_sel[i] = 1'b1;
        any_ch      = 1'b1;
      end
    end
    dsp_sel = !any_ch && dsp_req;
    cpu_sel = !any_ch && !dsp_req && cpu_req;
  end
endmodule

// File: rtl/arb_ring_pick.sv
module arb_ring_pick #(
  parameter int NUM_CAND = 5,
  parameter int IDX_W    = $clog2(NUM_CAND)
) (
  input  logic [NUM_CAND-1:0] cand_req,
  input  logic [IDX_W-1:0]    start,
  output logic                hit,
  output logic [IDX_W-1:0]    win
);
  logic [IDX_W:0]   sum_w;
  logic [IDX_W-1:0] pos;

  // first requesting position at or after start, wrapping
  always_comb begin
    hit   = 1'b0;
    win   = '0;
    sum_w = '0;
    pos   = '0;
    for (int k = 0; k < NUM_CAND; k++) begin
      sum_w = {1'b0, start} + (IDX_W+1)'(k);
      if (sum_w >= (IDX_W+1)'(NUM_CAND)) sum_w = sum_w - (IDX_W+1)'(NUM_CAND);
      pos = sum_w[IDX_W-1:0];
      if (!hit && cand_req[pos]) begin
        hit = 1'b1;
        win = pos;
      end
    end
  end
endmodule

// File: rtl/arb_ring_state.sv
module arb_ring_state #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 15,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             proc_req,
  input  logic             pick_hit,
  input  logic [IDX_W-1:0] pick_win,
  input  logic [CNT_W-1:0] budget,
  output logic [IDX_W-1:0] ptr,
  output logic [CNT_W-1:0] rem,
  output logic             slot_active
);
  localparam logic [IDX_W-1:0] SLOT = IDX_W'(NUM_CH);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] ptr_n;
  logic [CNT_W-1:0] rem_n;

  assign slot_active = (ptr == SLOT) && (rem != '0);

  always_comb begin
    ptr_n = ptr;
    rem_n = rem;
    if (slot_active && proc_req) begin
      rem_n = rem - ONE;
      if (rem == ONE) ptr_n = '0;
    end else begin
      if (slot_active) begin
        rem_n = '0;
        ptr_n = '0;
      end
      if (pick_hit) begin
        if (pick_win == SLOT) begin
          rem_n = budget - ONE;
          ptr_n = (budget == ONE) ? '0 : SLOT;
        end else begin
          ptr_n = pick_win + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      rem <= '0;
    end else if (adv_en) begin
      ptr <= ptr_n;
      rem <= rem_n;
    end
  end

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= SLOT);

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> ($stable(ptr) && $stable(rem)));

  p_budget_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && slot_active && proc_req) |=> (rem == $past(rem) - ONE));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !pick_hit && !slot_active) |=> $stable(ptr));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && slot_active && !proc_req && !pick_hit) |=> (ptr == '0 && rem == '0));
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import arb_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int CODE_B = CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rot_mode,
  input  logic [CODE_B-1:0] yield_code,
  input  logic              legacy_req,
  input  logic [N_CH-1:0]   chan_req,
  input  logic              dsp_req,
  input  logic              cpu_req,
  output logic              legacy_gnt,
  output logic [N_CH-1:0]   chan_gnt,
  output logic              dsp_gnt,
  output logic              cpu_gnt
);
  localparam int CNT_B  = (1 << CODE_B) - 1;
  localparam int N_CAND = N_CH + 1;
  localparam int IW     = $clog2(N_CAND);
  localparam logic [IW-1:0] SLOT = IW'(N_CH);

  arb_policy_e      policy;
  logic [CNT_B-1:0] budget;
  logic             proc_req;
  logic [N_CAND-1:0] cand_req;
  logic [IW-1:0]    ptr, start, win;
  logic [CNT_B-1:0] rem;
  logic             slot_active, hit, adv_en;
  logic [N_CH-1:0]  fx_chan;
  logic             fx_dsp, fx_cpu;

  assign policy   = arb_policy_e'(rot_mode);
  assign proc_req = dsp_req || cpu_req;
  assign cand_req = {proc_req && (budget != '0), chan_req};
  assign start    = (slot_active && !proc_req) ? '0 : ptr;
  assign adv_en   = (policy == POL_ROTATE) && !legacy_req;

  arb_budget_decode #(.CODE_W(CODE_B), .CNT_W(CNT_B)) u_budget (
    .code   (yield_code),
    .cycles (budget)
  );

  arb_fixed_pick #(.NUM_CH(N_CH)) u_fixed (
    .chan_req (chan_req),
    .dsp_req  (dsp_req),
    .cpu_req  (cpu_req),
    .chan_sel (fx_chan),
    .dsp_sel  (fx_dsp),
    .cpu_sel  (fx_cpu)
  );

  arb_ring_pick #(.NUM_CAND(N_CAND), .IDX_W(IW)) u_ring (
    .cand_req (cand_req),
    .start    (start),
    .hit      (hit),
    .win      (win)
  );

  arb_ring_state #(.NUM_CH(N_CH), .CNT_W(CNT_B), .IDX_W(IW)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_en      (adv_en),
    .proc_req    (proc_req),
    .pick_hit    (hit),
    .pick_win    (win),
    .budget      (budget),
    .ptr         (ptr),
    .rem         (rem),
    .slot_active (slot_active)
  );

  always_comb begin
    legacy_gnt = 1'b0;
    chan_gnt   = '0;
    dsp_gnt    = 1'b0;
    cpu_gnt    = 1'b0;
    if (legacy_req) begin
      legacy_gnt = 1'b1;
    end else if (policy == POL_FIXED) begin
      chan_gnt = fx_chan;
      dsp_gnt  = fx_dsp;
      cpu_gnt  = fx_cpu;
    end else if ((slot_active && proc_req) || (hit && win == SLOT)) begin
      dsp_gnt = dsp_req;
      cpu_gnt = !dsp_req && cpu_req;
    end else if (hit) begin
      for (int i = 0; i < N_CH; i++)
        chan_gnt[i] = (win == IW'(i));
    end
  end

  p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({legacy_gnt, chan_gnt, dsp_gnt, cpu_gnt}));

  p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_gnt & ~chan_req) == '0) && (!dsp_gnt || dsp_req) && (!cpu_gnt || cpu_req));

  p_legacy_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_req |-> (legacy_gnt && chan_gnt == '0 && !dsp_gnt && !cpu_gnt));

  p_dsp_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_gnt |-> !dsp_req);

  p_fixed_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_mode && !legacy_req && chan_req[0]) |-> chan_gnt[0]);

  p_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_req && chan_req == '0 && !proc_req) |->
      (chan_gnt == '0 && !dsp_gnt && !cpu_gnt && !legacy_gnt));
endmodule

// File: tb/bus_grant_arbiter_test.sv
module bus_grant_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] G0   = 7'b0000000;
  localparam logic [6:0] GLEG = 7'b1000000;
  localparam logic [6:0] GC0  = 7'b0000100;
  localparam logic [6:0] GC1  = 7'b0001000;
  localparam logic [6:0] GC2  = 7'b0010000;
  localparam logic [6:0] GC3  = 7'b0100000;
  localparam logic [6:0] GDSP = 7'b0000010;
  localparam logic [6:0] GCPU = 7'b0000001;

  logic clk = 1'b0;
  logic rst_n;
  logic rot_mode;
  logic [3:0] yield_code;
  logic legacy_req, dsp_req, cpu_req;
  logic [3:0] chan_req;
  logic legacy_gnt, dsp_gnt, cpu_gnt;
  logic [3:0] chan_gnt;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_grant_arbiter uut (
    .clk(clk), .rst_n(rst_n), .rot_mode(rot_mode), .yield_code(yield_code),
    .legacy_req(legacy_req), .chan_req(chan_req), .dsp_req(dsp_req),
    .cpu_req(cpu_req), .legacy_gnt(legacy_gnt), .chan_gnt(chan_gnt),
    .dsp_gnt(dsp_gnt), .cpu_gnt(cpu_gnt)
  );

  function automatic logic [6:0] grants();
    return {legacy_gnt, chan_gnt, dsp_gnt, cpu_gnt};
  endfunction

  task automatic check(input logic [6:0] got, input logic [6:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ch, input logic d, input logic c, input logic lg,
                       output logic [6:0] got);
    @(negedge clk);
    chan_req = ch; dsp_req = d; cpu_req = c; legacy_req = lg;
    #1;
    got = grants();
  endtask

  task automatic step(input logic [3:0] ch, input logic d, input logic c, input logic lg,
                      input logic [6:0] exp, input string tag);
    logic [6:0] got;
    drive(ch, d, c, lg, got);
    check(got, exp, tag);
  endtask

  task automatic do_reset(input logic mode, input logic [3:0] code);
    @(negedge clk);
    rst_n = 1'b0; rot_mode = mode; yield_code = code;
    chan_req = '0; dsp_req = 0; cpu_req = 0; legacy_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1, 4'd1);
    step(4'b0000, 0, 0, 0, G0, "R9 reset idle");
    step(4'b1111, 0, 0, 0, GC0, "R4 ring starts at channel 0");
  endtask

  task automatic t_fixed();
    do_reset(1'b0, 4'd3);
    step(4'b1010, 1, 1, 0, GC1, "R2 lowest channel");
    step(4'b1010, 1, 1, 0, GC1, "R1 fixed keeps no rotation");
    step(4'b1000, 0, 0, 0, GC3, "R2 channel 3 alone");
    step(4'b0000, 1, 1, 0, GDSP, "R7 fixed dsp over cpu");
    step(4'b0000, 0, 1, 0, GCPU, "R2 cpu last");
    step(4'b0001, 1, 1, 1, GLEG, "R3 legacy in fixed");
  endtask

  task automatic t_rotate_full();
    do_reset(1'b1, 4'd3);
    step(4'b1111, 1, 1, 0, GC0, "R4 ch0");
    step(4'b1111, 1, 1, 0, GC1, "R4 ch1");
    step(4'b1111, 1, 1, 0, GC2, "R4 ch2");
    step(4'b1111, 1, 1, 0, GC3, "R4 ch3");
    for (int i = 0; i < 4; i++) step(4'b1111, 1, 1, 0, GDSP, "R6 R7 slot 4 cycles");
    step(4'b1111, 1, 1, 0, GC0, "R6 wrap to ch0 after budget");
  endtask

  task automatic t_skip();
    do_reset(1'b1, 4'd2);
    step(4'b1010, 0, 0, 0, GC1, "R5 skip ch0");
    step(4'b1010, 0, 0, 0, GC3, "R5 skip ch2");
    step(4'b1010, 0, 0, 0, GC1, "R5 skip empty slot and ch0");
  endtask

  task automatic t_budget_zero_one();
    do_reset(1'b1, 4'd0);
    for (int i = 0; i < 4; i++) step(4'b1111, 0, 1, 0, GC0 << i, "R6 code 0 channels");
    step(4'b1111, 0, 1, 0, GC0, "R6 code 0 slot never granted");
    step(4'b0000, 0, 1, 0, G0, "R6 code 0 cpu alone no grant");
    do_reset(1'b1, 4'd1);
    for (int i = 0; i < 4; i++) step(4'b1111, 0, 1, 0, GC0 << i, "R4 channels code 1");
    step(4'b1111, 0, 1, 0, GCPU, "R6 code 1 single cpu cycle");
    step(4'b1111, 0, 1, 0, GC0, "R6 code 1 back to ch0");
  endtask

  task automatic t_early_release();
    do_reset(1'b1, 4'd4);
    step(4'b0001, 1, 0, 0, GC0, "R8 ch0 first");
    step(4'b0001, 1, 0, 0, GDSP, "R8 slot entered");
    step(4'b0001, 1, 0, 0, GDSP, "R8 slot kept");
    step(4'b0001, 0, 0, 0, GC0, "R8 release restarts at ch0");
    step(4'b0001, 0, 1, 0, GCPU, "R8 fresh slot for cpu");
  endtask

  task automatic t_legacy_rotate();
    do_reset(1'b1, 4'd2);
    step(4'b1111, 0, 0, 0, GC0, "R4 ch0 before legacy");
    step(4'b1111, 1, 1, 1, GLEG, "R3 legacy overrides");
    step(4'b1111, 1, 1, 1, GLEG, "R3 legacy still");
    step(4'b1111, 1, 1, 0, GC1, "R3 rotation resumed");
  endtask

  task automatic t_idle_hold();
    do_reset(1'b1, 4'd2);
    step(4'b1111, 0, 0, 0, GC0, "R4 ch0");
    step(4'b1111, 0, 0, 0, GC1, "R4 ch1");
    step(4'b0000, 0, 0, 0, G0, "R9 idle no grant");
    step(4'b0000, 0, 0, 0, G0, "R9 idle again");
    step(4'b1111, 0, 0, 0, GC2, "R9 pointer held");
  endtask

  task automatic t_max_budget();
    logic [6:0] got;
    int n;
    do_reset(1'b1, 4'd15);
    for (int i = 0; i < 4; i++) step(4'b1111, 1, 0, 0, GC0 << i, "R4 channels code 15");
    n = 0;
    for (int i = 0; i < 16384; i++) begin
      drive(4'b1111, 1, 0, 0, got);
      if (got == GDSP) n++;
    end
    check(7'(n == 16384), 7'd1, "R6 code 15 gives 16384 dsp cycles");
    step(4'b1111, 1, 0, 0, GC0, "R6 ch0 after max budget");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rot_mode = 0; yield_code = 0;
    chan_req = '0; dsp_req = 0; cpu_req = 0; legacy_req = 0;
    t_reset_state();
    t_fixed();
    t_rotate_full();
    t_skip();
    t_budget_zero_one();
    t_early_release();
    t_legacy_rotate();
    t_idle_hold();
    t_max_budget();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule